// File: doc/BRIEF.md
# Staged Pipeline Clock-Enable Distributor

This block turns one enable from a clock scheduler into the clock enables of a three-stage pipeline. A scheduler lowers the effective clock rate of the pipeline by withholding master-clock pulses. This block decides which stage registers receive each pulse.

In global mode, all three stages follow the scheduler enable together. In distributed mode, the enable reaches the output stage (stage three) first. It reaches the middle stage one cycle later, and the first stage two cycles after the middle stage.

Every enable leaves the block through a level-sensitive gate cell. The gate cell is transparent while the master clock is low, so a gated clock built from it cannot glitch. The write enable of the input buffer has a gate cell of its own that ignores the scheduler, so arriving flits are never lost.

The block also holds the output word. While the output stage is not clocked, the top bit of the output word reads as 0, which marks the word invalid for whoever samples it.

Top module: `stage_enable_distributor`

## Requirements
- R1: When the active mode is global (0), all three stage enables equal the scheduler enable of the same cycle.
- R2: When the active mode is distributed (1), the stage-three enable equals the scheduler enable of the same cycle.
- R3: In distributed mode, the stage-two enable equals the stage-three enable of the previous cycle.
- R4: In distributed mode, the stage-one enable equals the stage-two enable of two cycles earlier.
- R5: The buffer write enable follows the write-valid input in every mode and for any scheduler enable.
- R6: The output word register loads the data input at a clock edge only if the stage-three enable was high in the cycle before that edge. Otherwise it keeps its value.
- R7: While the stage-three enable is low, bit DATA_W-1 of the data output is 0 and the valid output is 0. While it is high, the data output is the stored word and the valid output equals that word's top bit.
- R8: Each enable output is held by a gate cell that is transparent only while the clock is low. An input change during the high phase does not reach the outputs until the clock falls.
- R9: A new value on the mode select (0 = global, 1 = distributed) takes effect at a clock edge only if the scheduler enable is 0 in the cycle before the edge and was also 0 in the three cycles before that. Otherwise the active mode is kept.
- R10: During and right after reset, every stage enable, the buffer write enable, the valid output and the data output are 0, and the active mode is global.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| schedEn | input | 1 | Enable from the clock scheduler |
| modeSel | input | 1 | Requested mode: 0 global, 1 distributed |
| wrValidIn | input | 1 | A flit is arriving for the input buffer |
| dataIn | input | DATA_W | Word presented to the output stage |
| stageEn | output | 3 | Stage enables: bit 0 stage one, bit 2 stage three (output) |
| fifoWrEn | output | 1 | Gated write enable of the input buffer |
| dataOut | output | DATA_W | Output word with its top bit used as validity |
| outValid | output | 1 | Output word is valid |

## Verification
The hardest condition to reach is a mode request that arrives while an enable is still moving backward through the distributed chain. The switch has to be refused until three quiet scheduler cycles have passed, and then taken.

Random stimulus alone seldom produces that long a quiet run, so it biases the scheduler enable low in some phases. Directed sequences add two cases: a single-cycle pulse followed by a mode flip that must be held off, and input changes made in the high clock phase to test the transparency of the gate cells.

// File: rtl/stage_enable_pkg.sv
package stage_enable_pkg;
  localparam int NUM_STAGES = 3;
  localparam int HOP_LATE   = 1;  // output stage -> middle stage
  localparam int HOP_EARLY  = 2;  // middle stage -> first stage
  localparam int CHAIN_LEN  = HOP_LATE + HOP_EARLY;

  typedef enum logic {MODE_GLOBAL = 1'b0, MODE_DIST = 1'b1} gateMode_t;

  typedef struct packed {
    logic captureOut;  // output stage clocked this cycle
    logic qualifyOut;  // output word may be presented as valid
  } outStrobe_t;
endpackage

// File: rtl/gate_cell.sv
module gate_cell (
  input  logic clk,
  input  logic rstN,
  input  logic enReq,
  output logic enHeld
);
  always_latch begin
    if (!rstN)     enHeld <= 1'b0;
    else if (!clk) enHeld <= enReq;
  end
endmodule

// File: rtl/stage_enable_ctrl.sv
module stage_enable_ctrl
  import stage_enable_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic schedEn,
  input  logic modeSel,
  input  logic wrValidIn,
  output logic [NUM_STAGES-1:0] stageEn,
  output logic fifoWrEn,
  output outStrobe_t strobes
);
  gateMode_t modeActive;
  logic [CHAIN_LEN-1:0] chain;
  logic [NUM_STAGES-1:0] stageReq;
  logic chainIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_LEN-2:0], schedEn};
  end

  assign chainIdle = (chain == '0) && !schedEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          modeActive <= MODE_GLOBAL;
    else if (chainIdle) modeActive <= gateMode_t'(modeSel);
  end

  always_comb begin
    if (modeActive == MODE_GLOBAL) begin
      stageReq = {NUM_STAGES{schedEn}};
    end else begin
      stageReq[2] = schedEn;
      stageReq[1] = chain[HOP_LATE-1];
      stageReq[0] = chain[CHAIN_LEN-1];
    end
  end

  genvar s;
  generate
    for (s = 0; s < NUM_STAGES; s++) begin : g_stageGate
      gate_cell u_cell (.clk(clk), .rstN(rstN), .enReq(stageReq[s]), .enHeld(stageEn[s]));
    end
  endgenerate

  gate_cell u_wrCell (.clk(clk), .rstN(rstN), .enReq(wrValidIn), .enHeld(fifoWrEn));

  assign strobes.captureOut = stageEn[NUM_STAGES-1];
  assign strobes.qualifyOut = stageEn[NUM_STAGES-1];

  AST_GLOBAL_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive == MODE_GLOBAL) |-> (stageEn == '0 || stageEn == '1)); // R1
  AST_MID_HOP: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive == MODE_DIST && $past(modeActive) == MODE_DIST)
      |-> stageEn[1] == $past(stageEn[2])); // R3
  AST_FIRST_HOP: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive == MODE_DIST && $past(modeActive) == MODE_DIST && $past(modeActive, 2) == MODE_DIST)
      |-> stageEn[0] == $past(stageEn[1], 2)); // R4
  AST_MODE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeActive) |-> ($past(stageEn) == '0)); // R9
endmodule

// File: rtl/stage_out_path.sv
module stage_out_path
  import stage_enable_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  outStrobe_t strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic outValid
);
  localparam int VBIT = DATA_W - 1;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   outReg <= '0;
    else if (strobes.captureOut) outReg <= dataIn;
  end

  always_comb begin
    dataOut       = outReg;
    dataOut[VBIT] = outReg[VBIT] & strobes.qualifyOut;
  end
  assign outValid = dataOut[VBIT];
endmodule

// File: rtl/stage_enable_distributor.sv
module stage_enable_distributor
  import stage_enable_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic schedEn,
  input  logic modeSel,
  input  logic wrValidIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [NUM_STAGES-1:0] stageEn,
  output logic fifoWrEn,
  output logic [DATA_W-1:0] dataOut,
  output logic outValid
);
  outStrobe_t strobes;

  stage_enable_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .schedEn(schedEn), .modeSel(modeSel),
    .wrValidIn(wrValidIn), .stageEn(stageEn), .fifoWrEn(fifoWrEn), .strobes(strobes)
  );

  stage_out_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobes(strobes),
    .dataOut(dataOut), .outValid(outValid)
  );

  AST_GATED_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    !stageEn[NUM_STAGES-1] |-> (!outValid && !dataOut[DATA_W-1])); // R7
endmodule

// File: tb/stage_enable_distributor_test.sv
module stage_enable_distributor_test;
  localparam int PERIOD = 10;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic schedEn = 1'b0, modeSel = 1'b0, wrValidIn = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [2:0] stageEn;
  logic fifoWrEn, outValid;
  logic [DW-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model state
  logic eMode = 1'b0;
  logic [2:0] eChain = '0;
  logic [DW-1:0] eOut = '0;

  stage_enable_distributor #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .schedEn(schedEn), .modeSel(modeSel),
    .wrValidIn(wrValidIn), .dataIn(dataIn), .stageEn(stageEn),
    .fifoWrEn(fifoWrEn), .dataOut(dataOut), .outValid(outValid)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expStages(logic m, logic s, logic [2:0] ch);
    if (!m) return {3{s}};
    return {s, ch[0], ch[2]};
  endfunction

  function automatic logic [DW-1:0] expData(logic st3, logic [DW-1:0] o);
    logic [DW-1:0] r = o;
    r[DW-1] = o[DW-1] & st3;
    return r;
  endfunction

  // drive in the low phase, check before the rising edge, then advance the model
  task automatic stepCycle(logic s, logic m, logic w, logic [DW-1:0] d);
    logic [2:0] es;
    logic [DW-1:0] ed;
    @(negedge clk);
    #1;
    schedEn = s; modeSel = m; wrValidIn = w; dataIn = d;
    #3;
    es = expStages(eMode, s, eChain);
    ed = expData(es[2], eOut);
    if (!eMode) check("R1 global stages", {61'd0, stageEn}, {61'd0, es});
    else begin
      check("R2 stage3", {63'd0, stageEn[2]}, {63'd0, es[2]});
      check("R3 stage2", {63'd0, stageEn[1]}, {63'd0, es[1]});
      check("R4 stage1", {63'd0, stageEn[0]}, {63'd0, es[0]});
    end
    check("R5 fifo write", {63'd0, fifoWrEn}, {63'd0, w});
    check("R6 R7 data out", dataOut, ed);
    check("R7 valid", {63'd0, outValid}, {63'd0, ed[DW-1]});
    if (es[2]) eOut = d;
    if (!s && eChain == 3'b000) eMode = m;
    eChain = {eChain[1:0], s};
  endtask

  function automatic logic [DW-1:0] rndWord();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset stages", {61'd0, stageEn}, 64'd0);
    check("R10 reset fifo", {63'd0, fifoWrEn}, 64'd0);
    check("R10 reset data", dataOut, 64'd0);
    @(negedge clk); #1; rstN = 1'b1;
    #3;
    check("R10 after release stages", {61'd0, stageEn}, 64'd0);
    check("R10 after release valid", {63'd0, outValid}, 64'd0);

    // global mode, valid word while enabled, then gated
    stepCycle(1, 0, 1, {1'b1, 63'h55});
    stepCycle(0, 0, 1, {1'b1, 63'h66});   // R7: word held but invalid
    stepCycle(1, 0, 0, {1'b0, 63'h77});
    stepCycle(0, 0, 0, '0);
    stepCycle(0, 0, 0, '0);
    stepCycle(0, 0, 0, '0);
    // switch to distributed while idle (R9)
    stepCycle(0, 1, 0, '0);
    // single pulse travels backward: R2 R3 R4
    stepCycle(1, 1, 0, {1'b1, 63'h1});
    // mode flip requested while chain busy must be refused (R9)
    for (int i = 0; i < 4; i++) stepCycle(0, 0, 1, {1'b1, 63'h2});
    for (int i = 0; i < 3; i++) stepCycle(0, 0, 0, '0);
    // R8: change during high phase does not reach outputs
    @(posedge clk); #2;
    begin
      logic [2:0] held = stageEn;
      logic hw = fifoWrEn;
      schedEn = ~schedEn; wrValidIn = ~wrValidIn;
      #1;
      check("R8 stages held in high phase", {61'd0, stageEn}, {61'd0, held});
      check("R8 fifo held in high phase", {63'd0, fifoWrEn}, {63'd0, hw});
      schedEn = ~schedEn; wrValidIn = ~wrValidIn;
    end

    // random phases, some biased quiet to let mode changes through
    for (int ph = 0; ph < 40; ph++) begin
      int quiet = (ph % 3 == 0);
      logic m = $urandom() % 2;
      for (int i = 0; i < 25; i++) begin
        logic s = quiet ? (($urandom() % 8) == 0) : $urandom() % 2;
        logic mm = (($urandom() % 4) == 0) ? ~m : m;
        stepCycle(s, mm, $urandom() % 2, rndWord());
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule